// File: doc/BRIEF.md
# Store-Exclusive Halfword Execution Unit

This unit executes one conditional halfword store per instruction word. It decodes the 32-bit word and takes the status, base and source register indices from it. It reads the base address and the source value through two combinational register-file read ports; base index 31 selects the stack pointer instead. The store is committed only when a single-entry reservation, armed earlier by a load-exclusive, still covers the target address. In every executed case a 0 (stored) or 1 (not stored) status is written back to the register file.

Parameters set how the unit handles an instruction whose status register aliases the source or the base register. It can flag the word as undefined, drop it as a no-op, or go on with a fixed substitute value or address. A parameter also sets whether a misaligned address raises an alignment fault when the reservation check fails. All results are registered: the memory write, the status write and the fault flags are one-cycle pulses in the cycle after the instruction is presented.

Top module: `excl_store_half`

## Requirements
- R1: A word is executed only when `insn_valid` is high, bits [31:21] equal 01001000000, bit 15 is 0 and bits [14:10] are 11111. Any other word produces no output pulse and leaves the reservation unchanged. The status index is bits [20:16], the base index bits [9:5] and the source index bits [4:0].
- R2: A committed store pulses `mem_wr_valid` for one cycle, in the cycle after the instruction. It carries the 64-bit base register value as the address (no offset), the low 16 bits of the source register as data, and `mem_wr_be` = 2'b11. Source index 31 reads as zero.
- R3: With base index 31 the address is `sp_value`. If `sp_value` is not a multiple of `SP_ALIGN` (16 by default), `sp_align_fault` pulses instead, and neither memory nor the register file is written.
- R4: An executed instruction that raises no fault writes, one cycle later, `rf_wr_data` = 0 to the status index when it stored, or 1 when it did not. Bits [31:1] are always zero.
- R5: The reservation check passes only when the reservation is valid and its address equals the store address with bit 0 ignored. A store is committed only on a pass.
- R6: `ld_excl_valid` arms the reservation with `ld_excl_addr`. Every executed store-exclusive disarms it, whether it stored, failed or faulted. When both happen on the same edge, the store sees the old reservation and the reservation ends up armed with the new address.
- R7: When the status index equals the source index, `DATA_OVL_MODE` applies: 0 stores `ARB_DATA` in place of the register value, 1 pulses `undef_insn` with no other effect, and 2 does nothing.
- R8: When the status index equals the base index and the base index is not 31, `BASE_OVL_MODE` applies: 0 uses `ARB_ADDR` as the address, 1 pulses `undef_insn`, and 2 does nothing. If the source overlap also applies and its mode is 1 or 2, the source overlap decides.
- R9: An odd address combined with a passing check pulses `align_fault` with no memory write and no status write.
- R10: An odd address combined with a failing check pulses `align_fault` (no status write) when `FAULT_ON_FAIL` is 1. When it is 0, the instruction writes status 1 with no fault.
- R11: After reset all output pulses are low and the reservation is disarmed, so a first store-exclusive reports status 1.
- R12: An instruction resolved as undefined or no-op leaves the reservation as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_valid | input | 1 | Instruction word present this cycle |
| insn | input | 32 | Instruction word |
| sp_value | input | 64 | Current stack pointer |
| rf_base_idx | output | 5 | Read index for the base register |
| rf_base_data | input | 64 | Value of the base register |
| rf_data_idx | output | 5 | Read index for the source register |
| rf_data_data | input | 64 | Value of the source register |
| ld_excl_valid | input | 1 | Arm the reservation this cycle |
| ld_excl_addr | input | 64 | Address to reserve |
| mem_wr_valid | output | 1 | Memory write pulse |
| mem_wr_addr | output | 64 | Memory write address |
| mem_wr_data | output | 16 | Memory write data |
| mem_wr_be | output | 2 | Byte enables |
| rf_wr_valid | output | 1 | Status write pulse |
| rf_wr_idx | output | 5 | Status register index |
| rf_wr_data | output | 32 | Status value, zero-extended |
| align_fault | output | 1 | Halfword misalignment fault pulse |
| sp_align_fault | output | 1 | Stack pointer misalignment fault pulse |
| undef_insn | output | 1 | Undefined-instruction pulse |

## Verification
The bench drives two instances from the same stimulus. The first uses the defaults for overlap handling (mode 0 for both) with `ARB_DATA` = 16'hA5C3, `ARB_ADDR` = 64'h1000 and `FAULT_ON_FAIL` = 0. This makes the substituted data and address visible on the write port, and it shows that a failed odd-address store writes only a status. The second uses `DATA_OVL_MODE` = 1, `BASE_OVL_MODE` = 2 and `FAULT_ON_FAIL` = 1. It exercises the undefined and no-op outcomes, the priority of the source overlap over the base overlap, and faults on failed odd stores. Addresses are drawn from a small pool so that reservation hits, near misses on bit 0 and stale reservations all occur often.

// File: rtl/excl_store_half.sv
module excl_store_half #(
  parameter int          AW            = 64,
  parameter int          DW            = 16,
  parameter int          SP_ALIGN      = 16,
  parameter int          DATA_OVL_MODE = 0,
  parameter int          BASE_OVL_MODE = 0,
  parameter bit          FAULT_ON_FAIL = 1'b0,
  parameter logic [15:0] ARB_DATA      = 16'h0000,
  parameter logic [63:0] ARB_ADDR      = 64'h0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          insn_valid,
  input  logic [31:0]   insn,
  input  logic [AW-1:0] sp_value,
  output logic [4:0]    rf_base_idx,
  input  logic [AW-1:0] rf_base_data,
  output logic [4:0]    rf_data_idx,
  input  logic [AW-1:0] rf_data_data,
  input  logic          ld_excl_valid,
  input  logic [AW-1:0] ld_excl_addr,
  output logic          mem_wr_valid,
  output logic [AW-1:0] mem_wr_addr,
  output logic [DW-1:0] mem_wr_data,
  output logic [1:0]    mem_wr_be,
  output logic          rf_wr_valid,
  output logic [4:0]    rf_wr_idx,
  output logic [31:0]   rf_wr_data,
  output logic          align_fault,
  output logic          sp_align_fault,
  output logic          undef_insn
);
  localparam int SP_LSB = $clog2(SP_ALIGN);
  localparam int M_SUB = 0, M_UNDEF = 1, M_NOP = 2;

  logic [4:0] rs, rn, rt;
  assign rs = insn[20:16];
  assign rn = insn[9:5];
  assign rt = insn[4:0];
  assign rf_base_idx = rn;
  assign rf_data_idx = rt;

  logic hit;
  assign hit = insn_valid && insn[31:21] == 11'b01001000000 && !insn[15] && insn[14:10] == 5'h1f;

  logic d_ovl, b_ovl, d_undef, d_nop, b_undef, b_nop, is_undef, is_nop, exec;
  assign d_ovl   = rs == rt;
  assign b_ovl   = rs == rn && rn != 5'd31;
  assign d_undef = d_ovl && DATA_OVL_MODE == M_UNDEF;
  assign d_nop   = d_ovl && DATA_OVL_MODE == M_NOP;
  assign b_undef = !d_undef && !d_nop && b_ovl && BASE_OVL_MODE == M_UNDEF;
  assign b_nop   = !d_undef && !d_nop && b_ovl && BASE_OVL_MODE == M_NOP;
  assign is_undef = d_undef || b_undef;
  assign is_nop   = d_nop || b_nop;
  assign exec     = hit && !is_undef && !is_nop;

  logic [AW-1:0] addr;
  logic [DW-1:0] data;
  assign addr = (rn == 5'd31) ? sp_value : (b_ovl ? ARB_ADDR[AW-1:0] : rf_base_data);
  assign data = d_ovl ? ARB_DATA[DW-1:0] : rf_data_data[DW-1:0];

  logic          mon_v;
  logic [AW-1:0] mon_tag;

  logic sp_bad, pass, misal, fault_al, do_status, do_store;
  assign sp_bad    = rn == 5'd31 && |sp_value[SP_LSB-1:0];
  assign pass      = mon_v && mon_tag[AW-1:1] == addr[AW-1:1];
  assign misal     = addr[0];
  assign fault_al  = exec && !sp_bad && misal && (pass || FAULT_ON_FAIL);
  assign do_status = exec && !sp_bad && !fault_al;
  assign do_store  = do_status && pass;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mon_v   <= 1'b0;
      mon_tag <= '0;
    end else if (ld_excl_valid) begin
      mon_v   <= 1'b1;
      mon_tag <= ld_excl_addr;
    end else if (exec) begin
      mon_v   <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_wr_valid   <= 1'b0;
      rf_wr_valid    <= 1'b0;
      align_fault    <= 1'b0;
      sp_align_fault <= 1'b0;
      undef_insn     <= 1'b0;
      mem_wr_addr    <= '0;
      mem_wr_data    <= '0;
      rf_wr_idx      <= '0;
      rf_wr_data     <= '0;
    end else begin
      mem_wr_valid   <= do_store;
      rf_wr_valid    <= do_status;
      align_fault    <= fault_al;
      sp_align_fault <= exec && sp_bad;
      undef_insn     <= hit && is_undef;
      if (do_store) begin
        mem_wr_addr <= addr;
        mem_wr_data <= data;
      end
      if (do_status) begin
        rf_wr_idx  <= rs;
        rf_wr_data <= {31'd0, !pass};
      end
    end
  end

  assign mem_wr_be = 2'b11;
endmodule

// File: rtl/excl_store_half_chk.sv
module excl_store_half_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mon_v,
  input logic        ld_excl_valid,
  input logic        mem_wr_valid,
  input logic [1:0]  mem_wr_be,
  input logic        rf_wr_valid,
  input logic [31:0] rf_wr_data,
  input logic        align_fault,
  input logic        sp_align_fault,
  input logic        undef_insn
);
  p_store_has_status_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid |-> rf_wr_valid && rf_wr_data == 32'd0);
  p_status_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr_valid |-> rf_wr_data[31:1] == 31'd0);
  p_full_be_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid |-> mem_wr_be == 2'b11);
  p_store_needs_mon_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid |-> $past(mon_v));
  p_mon_cleared_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_wr_valid && !$past(ld_excl_valid)) |-> !mon_v);
  p_align_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    align_fault |-> !mem_wr_valid && !rf_wr_valid);
  p_sp_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sp_align_fault |-> !mem_wr_valid && !rf_wr_valid && !align_fault);
  p_undef_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    undef_insn |-> !mem_wr_valid && !rf_wr_valid && !align_fault && !sp_align_fault);
endmodule

bind excl_store_half excl_store_half_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mon_v(mon_v), .ld_excl_valid(ld_excl_valid),
  .mem_wr_valid(mem_wr_valid), .mem_wr_be(mem_wr_be), .rf_wr_valid(rf_wr_valid),
  .rf_wr_data(rf_wr_data), .align_fault(align_fault), .sp_align_fault(sp_align_fault),
  .undef_insn(undef_insn)
);

// File: tb/test_excl_store_half.sv
module test_excl_store_half;
  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        insn_valid = 1'b0, ld_excl_valid = 1'b0;
  logic [31:0] insn = '0;
  logic [63:0] sp_value = 64'h8000, ld_excl_addr = '0;
  logic [63:0] regs [32];

  logic [4:0]  a_bi, a_di, b_bi, b_di, a_wi, b_wi;
  logic [63:0] a_ma, b_ma;
  logic [15:0] a_md, b_md;
  logic [1:0]  a_be, b_be;
  logic [31:0] a_wd, b_wd;
  logic        a_mw, a_rw, a_af, a_sf, a_ud, b_mw, b_rw, b_af, b_sf, b_ud;

  excl_store_half #(.ARB_DATA(16'hA5C3), .ARB_ADDR(64'h1000)) i_excl_store_half (
    .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn(insn), .sp_value(sp_value),
    .rf_base_idx(a_bi), .rf_base_data(regs[a_bi]), .rf_data_idx(a_di),
    .rf_data_data(a_di == 5'd31 ? 64'd0 : regs[a_di]),
    .ld_excl_valid(ld_excl_valid), .ld_excl_addr(ld_excl_addr),
    .mem_wr_valid(a_mw), .mem_wr_addr(a_ma), .mem_wr_data(a_md), .mem_wr_be(a_be),
    .rf_wr_valid(a_rw), .rf_wr_idx(a_wi), .rf_wr_data(a_wd),
    .align_fault(a_af), .sp_align_fault(a_sf), .undef_insn(a_ud));

  excl_store_half #(.DATA_OVL_MODE(1), .BASE_OVL_MODE(2), .FAULT_ON_FAIL(1'b1)) i_excl_store_half_alt (
    .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn(insn), .sp_value(sp_value),
    .rf_base_idx(b_bi), .rf_base_data(regs[b_bi]), .rf_data_idx(b_di),
    .rf_data_data(b_di == 5'd31 ? 64'd0 : regs[b_di]),
    .ld_excl_valid(ld_excl_valid), .ld_excl_addr(ld_excl_addr),
    .mem_wr_valid(b_mw), .mem_wr_addr(b_ma), .mem_wr_data(b_md), .mem_wr_be(b_be),
    .rf_wr_valid(b_rw), .rf_wr_idx(b_wi), .rf_wr_data(b_wd),
    .align_fault(b_af), .sp_align_fault(b_sf), .undef_insn(b_ud));

  int checks = 0, fails = 0;
  bit done = 1'b0;
  bit mv [2];
  logic [63:0] mt [2];

  task automatic chk(input bit ok, input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc(input logic [4:0] s, input logic [4:0] n, input logic [4:0] t);
    return {11'b01001000000, s, 1'b0, 5'h1f, n, t};
  endfunction

  // Expected outcome per instance k (0: substitute modes, fault-free fail; 1: undef/nop, fault on fail)
  logic ex_mw [2], ex_rw [2], ex_af [2], ex_sf [2], ex_ud [2];
  logic [63:0] ex_ma [2];
  logic [15:0] ex_md [2];
  logic [31:0] ex_wd [2];
  logic [4:0]  ex_wi [2];

  task automatic predict(input int k);
    logic [4:0] s, n, t;
    logic hit, dov, bov, ud, np, ex, spbad, pass, af;
    logic [63:0] ad, dv;
    s = insn[20:16]; n = insn[9:5]; t = insn[4:0];
    hit = insn_valid && insn[31:21] == 11'b01001000000 && !insn[15] && insn[14:10] == 5'h1f;
    dov = s == t; bov = s == n && n != 5'd31;
    ud = 1'b0; np = 1'b0;
    if (k == 1) begin
      if (dov) ud = 1'b1;
      else if (bov) np = 1'b1;
    end
    ex = hit && !ud && !np;
    dv = (t == 5'd31) ? 64'd0 : regs[t];
    ad = (n == 5'd31) ? sp_value : ((bov && k == 0) ? 64'h1000 : regs[n]);
    spbad = n == 5'd31 && sp_value[3:0] != 4'd0;
    pass = mv[k] && mt[k][63:1] == ad[63:1];
    af = ex && !spbad && ad[0] && (pass || k == 1);
    ex_ud[k] = hit && ud;
    ex_sf[k] = ex && spbad;
    ex_af[k] = af;
    ex_rw[k] = ex && !spbad && !af;
    ex_mw[k] = ex_rw[k] && pass;
    ex_ma[k] = ad;
    ex_md[k] = (dov && k == 0) ? 16'hA5C3 : dv[15:0];
    ex_wd[k] = pass ? 32'd0 : 32'd1;
    ex_wi[k] = s;
    if (ld_excl_valid) begin mv[k] = 1'b1; mt[k] = ld_excl_addr; end
    else if (ex) mv[k] = 1'b0;
  endtask

  task automatic compare(input int k, input logic mw, rw, af, sf, ud, input logic [63:0] ma,
                         input logic [15:0] md, input logic [1:0] be, input logic [31:0] wd, input logic [4:0] wi);
    chk(mw == ex_mw[k], "R2", $sformatf("i%0d mem_wr_valid", k), 64'(mw), 64'(ex_mw[k]));
    if (mw && ex_mw[k]) begin
      chk(ma == ex_ma[k], "R2", $sformatf("i%0d addr", k), ma, ex_ma[k]);
      chk(md == ex_md[k], "R7", $sformatf("i%0d data", k), 64'(md), 64'(ex_md[k]));
      chk(be == 2'b11, "R2", $sformatf("i%0d be", k), 64'(be), 64'd3);
    end
    chk(rw == ex_rw[k], "R4", $sformatf("i%0d rf_wr_valid", k), 64'(rw), 64'(ex_rw[k]));
    if (rw && ex_rw[k]) begin
      chk(wd == ex_wd[k], "R4", $sformatf("i%0d status", k), 64'(wd), 64'(ex_wd[k]));
      chk(wi == ex_wi[k], "R4", $sformatf("i%0d status idx", k), 64'(wi), 64'(ex_wi[k]));
    end
    chk(af == ex_af[k], "R9", $sformatf("i%0d align_fault", k), 64'(af), 64'(ex_af[k]));
    chk(sf == ex_sf[k], "R3", $sformatf("i%0d sp_align_fault", k), 64'(sf), 64'(ex_sf[k]));
    chk(ud == ex_ud[k], "R8", $sformatf("i%0d undef_insn", k), 64'(ud), 64'(ex_ud[k]));
  endtask

  task automatic step(input logic iv, input logic [31:0] w, input logic lv, input logic [63:0] la);
    insn_valid = iv; insn = w; ld_excl_valid = lv; ld_excl_addr = la;
    predict(0);
    predict(1);
    @(posedge clk);
    @(negedge clk);
    compare(0, a_mw, a_rw, a_af, a_sf, a_ud, a_ma, a_md, a_be, a_wd, a_wi);
    compare(1, b_mw, b_rw, b_af, b_sf, b_ud, b_ma, b_md, b_be, b_wd, b_wi);
    insn_valid = 1'b0; ld_excl_valid = 1'b0;
  endtask

  function automatic logic [63:0] pick_addr(input int unsigned r);
    case (r % 6)
      0: return 64'h1000;
      1: return 64'h1001;
      2: return 64'h2000;
      3: return 64'h2002;
      4: return 64'h2003;
      default: return 64'h8000;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    for (int i = 0; i < 32; i++) regs[i] = 64'h1000 + 64'(i) * 2;
    mv[0] = 1'b0; mv[1] = 1'b0; mt[0] = '0; mt[1] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11: idle reset state
    chk(!a_mw && !a_rw && !a_af && !a_sf && !a_ud, "R11", "reset outputs i0", 64'({a_mw, a_rw, a_af, a_sf, a_ud}), 64'd0);
    chk(!b_mw && !b_rw && !b_af && !b_sf && !b_ud, "R11", "reset outputs i1", 64'({b_mw, b_rw, b_af, b_sf, b_ud}), 64'd0);
    regs[2] = 64'h2000; regs[3] = 64'h0000_0000_0000_BEEF;
    // R11: first store fails, status 1
    step(1'b1, enc(5'd1, 5'd2, 5'd3), 1'b0, '0);
    // R5/R2: reserve then store succeeds
    step(1'b0, '0, 1'b1, 64'h2000);
    step(1'b1, enc(5'd1, 5'd2, 5'd3), 1'b0, '0);
    // R6: reservation gone after use
    step(1'b1, enc(5'd1, 5'd2, 5'd3), 1'b0, '0);
    // R5: bit 0 ignored in the match, but odd address faults (R9 / R10)
    step(1'b0, '0, 1'b1, 64'h2001);
    regs[4] = 64'h2001;
    step(1'b1, enc(5'd1, 5'd4, 5'd3), 1'b0, '0);
    // R10: odd address, no reservation
    step(1'b1, enc(5'd1, 5'd4, 5'd3), 1'b0, '0);
    // R1: non-matching words ignored, reservation kept
    step(1'b0, '0, 1'b1, 64'h2000);
    step(1'b1, enc(5'd1, 5'd2, 5'd3) | 32'h0000_8000, 1'b0, '0);
    step(1'b1, enc(5'd1, 5'd2, 5'd3) ^ 32'h0040_0000, 1'b0, '0);
    step(1'b0, enc(5'd1, 5'd2, 5'd3), 1'b0, '0);
    step(1'b1, enc(5'd1, 5'd2, 5'd3), 1'b0, '0);
    // R3: stack pointer base, aligned then misaligned
    sp_value = 64'h8000;
    step(1'b0, '0, 1'b1, 64'h8000);
    step(1'b1, enc(5'd5, 5'd31, 5'd3), 1'b0, '0);
    sp_value = 64'h8008;
    step(1'b1, enc(5'd5, 5'd31, 5'd3), 1'b0, '0);
    sp_value = 64'h8000;
    // R7: source overlap (substitute on i0, undefined on i1); R12 reservation kept on i1
    step(1'b0, '0, 1'b1, 64'h2000);
    step(1'b1, enc(5'd3, 5'd2, 5'd3), 1'b0, '0);
    step(1'b1, enc(5'd1, 5'd2, 5'd3), 1'b0, '0);
    // R8: base overlap (substitute address on i0, no-op on i1)
    step(1'b0, '0, 1'b1, 64'h1000);
    step(1'b1, enc(5'd6, 5'd6, 5'd3), 1'b0, '0);
    step(1'b0, '0, 1'b1, 64'h2000);
    step(1'b1, enc(5'd6, 5'd6, 5'd3), 1'b0, '0);
    step(1'b1, enc(5'd1, 5'd2, 5'd3), 1'b0, '0);
    // R8: both overlaps, source overlap decides on i1
    step(1'b1, enc(5'd7, 5'd7, 5'd7), 1'b0, '0);
    // R6: simultaneous arm and store
    step(1'b0, '0, 1'b1, 64'h2000);
    step(1'b1, enc(5'd1, 5'd2, 5'd3), 1'b1, 64'h1000);
    regs[8] = 64'h1000;
    step(1'b1, enc(5'd1, 5'd8, 5'd3), 1'b0, '0);
    // Random mix
    for (int n = 0; n < 600; n++) begin
      int unsigned r;
      logic [31:0] w;
      r = $urandom;
      for (int j = 0; j < 8; j++) regs[j] = pick_addr($urandom) ^ 64'($urandom & 32'hffff_0000);
      for (int j = 0; j < 8; j++) if ($urandom % 2 == 0) regs[j] = pick_addr($urandom);
      sp_value = ($urandom % 4 == 0) ? 64'h8004 : pick_addr($urandom) & ~64'hf;
      w = enc(5'($urandom % 8), ($urandom % 5 == 0) ? 5'd31 : 5'($urandom % 8), 5'($urandom % 8));
      if (r % 13 == 0) w = w ^ (32'd1 << ($urandom % 32));
      step((r % 4) != 0, w, (r % 3) == 0, pick_addr($urandom));
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule